// File: doc/BRIEF.md
# Per-Channel Fault Flag Collector with Serial Clear

This block gathers the fault conditions of a multi-channel low-side driver and reports them in two ways at once. Each channel has a live status pin. It follows the channel input level while the channel is healthy, and it shows the inverse of that level while a filtered fault is present. The same conditions are also latched into sticky flags that a serial host reads. A single fault pin is high whenever any latched flag is set.

The five detector inputs per channel are overload, overtemperature, open load, under current and short to ground. Each arrives as a synchronous, already digitised comparator result. Every detector except overtemperature must stay asserted for a programmable number of clock cycles before it counts. Open load and short to ground are looked at only while the channel is commanded off. Under current and overload are looked at only while it is commanded on. Overload and overtemperature share one protective flag per channel.

The latched flags are cleared when the chip select rises at the end of a transfer that the serial shifter has marked valid. A channel in latching current-limit mode keeps its overload flag across such a clear while its input is still high.

Top module: `diag_flag_latch`

## Requirements
- R1: After reset, and whenever no qualified fault is present, `stat_pin[i]` equals `in_lvl[i]`.
- R2: A filtered detector (overload, open, under, short) is recognised only after it has been high, with its qualifier met, on `FILT_CYC` consecutive rising clock edges. `stat_pin` inverts after the `FILT_CYC`-th such edge. The latched flag sets one edge later. A pulse of `FILT_CYC-1` edges changes neither output.
- R3: While a filtered fault is recognised, `stat_pin[i] = ~in_lvl[i]`. After the first edge at which the detector is low, `stat_pin[i]` follows `in_lvl[i]` again, and nothing of this is held.
- R4: Latched flags stay set until a rising clock edge that samples `cs_n` high, samples `cs_n` low at the previous edge, and samples `frame_ok` high. From that edge on they read 0.
- R5: When `cl2_mode[i]=1` and `in_lvl[i]=1` at the clearing edge, the overload part of `flag_prot[i]` is kept. With `in_lvl[i]=0`, or with `cl2_mode[i]=0`, it is cleared.
- R6: `flag_prot[i]` is the OR of the latched filtered overload and the latched overtemperature. Overtemperature is not filtered and latches at the first edge that samples `otemp_det[i]` high, even for a one-cycle pulse.
- R7: Open load and short to ground count only while `ch_on[i]=0`. Under current and overload count only while `ch_on[i]=1`.
- R8: `fault_pin` is 1 exactly when any bit of `flag_prot`, `flag_open`, `flag_under` or `flag_short` of any channel is 1.
- R9: A filtered fault that is still present at a clear reads 0 for `FILT_CYC` edges after the clearing edge and reads 1 again after edge `FILT_CYC+1`.
- R10: A rising `cs_n` sampled with `frame_ok=0` leaves every latched flag unchanged.
- R11: Reset (`rst_n=0`) clears all flags and all filter progress, and `fault_pin` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_lvl | input | N_CH | Channel input pin levels |
| ch_on | input | N_CH | Commanded channel state, 1 = on |
| cl2_mode | input | N_CH | 1 = latching current-limit mode for the channel |
| ovl_det | input | N_CH | Overload comparator result |
| otemp_det | input | N_CH | Overtemperature comparator result |
| open_det | input | N_CH | Open-load comparator result |
| under_det | input | N_CH | Under-current comparator result |
| short_det | input | N_CH | Short-to-ground comparator result |
| cs_n | input | 1 | Serial chip select, active low |
| frame_ok | input | 1 | Shifter strobe: the transfer now ending was valid |
| stat_pin | output | N_CH | Live status per channel |
| flag_prot | output | N_CH | Latched protective flag (overload or overtemperature) |
| flag_open | output | N_CH | Latched open-load flag |
| flag_under | output | N_CH | Latched under-current flag |
| flag_short | output | N_CH | Latched short-to-ground flag |
| fault_pin | output | 1 | OR of all latched flags |

## Verification
The bench builds the block with two channels and a filter length of five cycles. At that length a four-cycle pulse and a five-cycle fault differ by one edge, so the exact filter boundary can be exercised directly. The relaunch of the filter after a clear also completes in a few cycles. Two channels let the latching current-limit hold on one channel be observed next to a normal clear on the other. The random phase then mixes detector, qualifier, chip-select and strobe activity across both channels.

// File: rtl/diag_pkg.sv
package diag_pkg;

   // Filtered detector kinds; the index is used to pick the per-kind lane.
   typedef enum logic [1:0] {
      K_OVL   = 2'd0,
      K_OPEN  = 2'd1,
      K_UNDER = 2'd2,
      K_SHORT = 2'd3
   } fkind_e;

   localparam int NUM_FK = 4;

   // Kinds looked at while the channel is commanded on.
   function automatic logic kind_needs_on(input int k);
      return (k == int'(K_OVL)) || (k == int'(K_UNDER));
   endfunction

endpackage

// File: rtl/diag_filter.sv
module diag_filter #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic restart,
   output logic hit
);

   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (restart || !cond)
         run_q <= '0;
      else if (run_q != LIM_V)
         run_q <= run_q + 1'b1;
   end

   assign hit = (run_q == LIM_V);

endmodule

// File: rtl/diag_flag_cell.sv
module diag_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= 1'b0;
      else if (clr)
         q <= 1'b0;
      else if (set)
         q <= 1'b1;
   end

endmodule

// File: rtl/diag_cs_edge.sv
module diag_cs_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic frame_ok,
   output logic clr
);

   logic cs_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cs_q <= 1'b1;
      else
         cs_q <= cs_n;
   end

   assign clr = cs_n & ~cs_q & frame_ok;

endmodule

// File: rtl/diag_flag_latch.sv
module diag_flag_latch #(
   parameter int N_CH     = 2,
   parameter int FILT_CYC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] in_lvl,
   input  logic [N_CH-1:0] ch_on,
   input  logic [N_CH-1:0] cl2_mode,
   input  logic [N_CH-1:0] ovl_det,
   input  logic [N_CH-1:0] otemp_det,
   input  logic [N_CH-1:0] open_det,
   input  logic [N_CH-1:0] under_det,
   input  logic [N_CH-1:0] short_det,
   input  logic            cs_n,
   input  logic            frame_ok,
   output logic [N_CH-1:0] stat_pin,
   output logic [N_CH-1:0] flag_prot,
   output logic [N_CH-1:0] flag_open,
   output logic [N_CH-1:0] flag_under,
   output logic [N_CH-1:0] flag_short,
   output logic            fault_pin
);
   import diag_pkg::*;

   localparam int N_FLAGS = N_CH * (NUM_FK + 1);

   if (N_CH < 1) begin : g_bad_ch
      $error("diag_flag_latch: N_CH must be at least 1");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("diag_flag_latch: FILT_CYC must be at least 1");
   end

   logic clr;

   diag_cs_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .frame_ok (frame_ok),
      .clr      (clr)
   );

   logic [N_CH-1:0][NUM_FK-1:0] lat_q;
   logic [N_CH-1:0]             ot_q;
   logic [N_CH-1:0]             cl_q;
   logic [N_FLAGS-1:0]          all_flags;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic [NUM_FK-1:0] raw;
      logic [NUM_FK-1:0] cond;
      logic [NUM_FK-1:0] hit;
      logic [NUM_FK-1:0] wipe;
      logic              ovl_keep;

      assign raw[int'(K_OVL)]   = ovl_det[c];
      assign raw[int'(K_OPEN)]  = open_det[c];
      assign raw[int'(K_UNDER)] = under_det[c];
      assign raw[int'(K_SHORT)] = short_det[c];

      // latching current-limit mode keeps overload while the input is high
      assign ovl_keep = cl2_mode[c] & in_lvl[c];

      for (genvar k = 0; k < NUM_FK; k++) begin : g_kind
         if (kind_needs_on(k)) begin : g_on
            assign cond[k] = raw[k] & ch_on[c];
         end else begin : g_off
            assign cond[k] = raw[k] & ~ch_on[c];
         end

         if (k == int'(K_OVL)) begin : g_wipe_ovl
            assign wipe[k] = clr & ~ovl_keep;
         end else begin : g_wipe_std
            assign wipe[k] = clr;
         end

         diag_filter #(.LIMIT(FILT_CYC)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .cond    (cond[k]),
            .restart (wipe[k]),
            .hit     (hit[k])
         );

         diag_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (hit[k]),
            .clr   (wipe[k]),
            .q     (lat_q[c][k])
         );
      end

      // overtemperature: no filter, no qualifier
      diag_flag_cell u_ot (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (otemp_det[c]),
         .clr   (clr),
         .q     (ot_q[c])
      );

      assign stat_pin[c]   = in_lvl[c] ^ (|hit | otemp_det[c]);
      assign cl_q[c]       = lat_q[c][int'(K_OVL)];
      assign flag_prot[c]  = cl_q[c] | ot_q[c];
      assign flag_open[c]  = lat_q[c][int'(K_OPEN)];
      assign flag_under[c] = lat_q[c][int'(K_UNDER)];
      assign flag_short[c] = lat_q[c][int'(K_SHORT)];
   end

   assign all_flags = {lat_q, ot_q};
   assign fault_pin = |all_flags;

endmodule

// File: rtl/diag_flag_chk.sv
module diag_flag_chk #(
   parameter int N_CH = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] in_lvl,
   input logic [N_CH-1:0] cl2_mode,
   input logic            cs_n,
   input logic            frame_ok,
   input logic [N_CH-1:0] stat_pin,
   input logic [N_CH-1:0] flag_prot,
   input logic [N_CH-1:0] flag_open,
   input logic [N_CH-1:0] flag_under,
   input logic [N_CH-1:0] flag_short,
   input logic [N_CH-1:0] cl_q,
   input logic            fault_pin
);

   logic cs_d;
   logic clr_d;
   logic clr_now;
   logic [4*N_CH-1:0] flags;

   assign clr_now = cs_n & ~cs_d & frame_ok;
   assign flags   = {flag_prot, flag_open, flag_under, flag_short};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         clr_d <= 1'b0;
      end else begin
         cs_d  <= cs_n;
         clr_d <= clr_now;
      end
   end

   // R4 / R10: a set flag only drops after a valid clear
   a_r10_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_now |=> ((flags & $past(flags)) == $past(flags)));

   // R4: open/under/short read 0 right after a valid clear
   a_r4_clear_open: assert property (@(posedge clk) disable iff (!rst_n)
      clr_now |=> (flag_open == '0 && flag_under == '0 && flag_short == '0));

   // R8: the fault pin only falls at a valid clear
   a_r8_fault_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_pin) |-> clr_d);

   for (genvar i = 0; i < N_CH; i++) begin : g_ck
      // R5: overload kept in latching mode while input high
      a_r5_cl2_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_now && cl2_mode[i] && in_lvl[i] && cl_q[i]) |=> cl_q[i]);

      // R2 / R3: a flag rises only after the status pin showed the fault
      a_r2_open_seen: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_open[i]) |-> $past(stat_pin[i] != in_lvl[i]));

      a_r2_short_seen: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_short[i]) |-> $past(stat_pin[i] != in_lvl[i]));
   end

endmodule

bind diag_flag_latch diag_flag_chk #(.N_CH(N_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_lvl     (in_lvl),
   .cl2_mode   (cl2_mode),
   .cs_n       (cs_n),
   .frame_ok   (frame_ok),
   .stat_pin   (stat_pin),
   .flag_prot  (flag_prot),
   .flag_open  (flag_open),
   .flag_under (flag_under),
   .flag_short (flag_short),
   .cl_q       (cl_q),
   .fault_pin  (fault_pin)
);

// File: tb/test_diag_flag_latch.sv
module test_diag_flag_latch;

   localparam int NC = 2;
   localparam int F  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC-1:0] in_lvl = '0, ch_on = '0, cl2_mode = '0;
   logic [NC-1:0] ovl_det = '0, otemp_det = '0, open_det = '0;
   logic [NC-1:0] under_det = '0, short_det = '0;
   logic cs_n = 1'b1, frame_ok = 1'b0;
   logic [NC-1:0] stat_pin, flag_prot, flag_open, flag_under, flag_short;
   logic fault_pin;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state: kinds 0 ovl, 1 open, 2 under, 3 short, 4 overtemp
   int run [NC][4];
   bit lat [NC][5];
   bit cs_prev;

   always #5 clk = ~clk;

   diag_flag_latch #(.N_CH(NC), .FILT_CYC(F)) i_diag_flag_latch (
      .clk(clk), .rst_n(rst_n), .in_lvl(in_lvl), .ch_on(ch_on),
      .cl2_mode(cl2_mode), .ovl_det(ovl_det), .otemp_det(otemp_det),
      .open_det(open_det), .under_det(under_det), .short_det(short_det),
      .cs_n(cs_n), .frame_ok(frame_ok), .stat_pin(stat_pin),
      .flag_prot(flag_prot), .flag_open(flag_open), .flag_under(flag_under),
      .flag_short(flag_short), .fault_pin(fault_pin));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit cond_of(int c, int k);
      case (k)
         0: return ovl_det[c] & ch_on[c];
         1: return open_det[c] & ~ch_on[c];
         2: return under_det[c] & ch_on[c];
         default: return short_det[c] & ~ch_on[c];
      endcase
   endfunction

   function automatic logic [NC-1:0] exp_stat();
      logic [NC-1:0] r;
      for (int c = 0; c < NC; c++) begin
         bit f = otemp_det[c];
         for (int k = 0; k < 4; k++) if (run[c][k] == F) f = 1;
         r[c] = in_lvl[c] ^ f;
      end
      return r;
   endfunction

   function automatic logic [NC-1:0] exp_flag(int k);
      logic [NC-1:0] r;
      for (int c = 0; c < NC; c++)
         r[c] = (k == 0) ? (lat[c][0] | lat[c][4]) : lat[c][k];
      return r;
   endfunction

   function automatic logic exp_fault();
      logic r = 0;
      for (int c = 0; c < NC; c++) for (int k = 0; k < 5; k++) r |= lat[c][k];
      return r;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < NC; c++) begin
         for (int k = 0; k < 4; k++) run[c][k] = 0;
         for (int k = 0; k < 5; k++) lat[c][k] = 0;
      end
      cs_prev = 1;
   endtask

   task automatic model_step();
      bit clr = cs_n && !cs_prev && frame_ok;
      for (int c = 0; c < NC; c++) begin
         for (int k = 0; k < 4; k++) begin
            bit wipe = clr && !(k == 0 && cl2_mode[c] && in_lvl[c]);
            bit hit  = (run[c][k] == F);
            bit cd   = cond_of(c, k);
            lat[c][k] = wipe ? 1'b0 : (lat[c][k] | hit);
            run[c][k] = (wipe || !cd) ? 0 : ((run[c][k] == F) ? F : run[c][k] + 1);
         end
         lat[c][4] = clr ? 1'b0 : (lat[c][4] | otemp_det[c]);
      end
      cs_prev = cs_n;
   endtask

   task automatic compare_all();
      chk("R3 stat_pin", stat_pin, exp_stat());
      chk("R4 flag_prot", flag_prot, exp_flag(0));
      chk("R4 flag_open", flag_open, exp_flag(1));
      chk("R4 flag_under", flag_under, exp_flag(2));
      chk("R4 flag_short", flag_short, exp_flag(3));
      chk("R8 fault_pin", fault_pin, exp_fault());
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         model_step();
         @(negedge clk);
         #1;
         compare_all();
      end
   endtask

   task automatic vclear(input bit ok);
      cs_n = 0; cyc(1);
      cs_n = 1; frame_ok = ok; cyc(1);
      frame_ok = 0;
   endtask

   initial begin
      model_reset();
      in_lvl = 2'b10;
      repeat (3) @(negedge clk);
      #1;
      // R11 reset state
      chk("R11 fault_pin", fault_pin, 0);
      chk("R11 flags", {flag_prot, flag_open, flag_under, flag_short}, 0);
      chk("R11 stat_pin", stat_pin, 2'b10);
      rst_n = 1;
      cyc(2);

      // R1 follow input
      in_lvl = 2'b01; #1;
      chk("R1 stat follows", stat_pin, 2'b01);
      cyc(2);

      // R2 short pulse on open, ch0 off
      open_det = 2'b01; cyc(F - 1);
      chk("R2 pulse stat", stat_pin, 2'b01);
      open_det = 2'b00; cyc(2);
      chk("R2 pulse no flag", flag_open, 0);

      // R2 / R3 full fault
      open_det = 2'b01; cyc(F);
      chk("R3 stat inverted", stat_pin, 2'b00);
      chk("R2 flag not yet", flag_open, 0);
      cyc(1);
      chk("R2 flag set", flag_open, 2'b01);
      chk("R8 fault high", fault_pin, 1);
      open_det = 0; cyc(1);
      chk("R3 stat restored", stat_pin, 2'b01);

      // R10 aborted transfer
      vclear(0);
      chk("R10 abort keeps", flag_open, 2'b01);
      // R4 valid clear
      vclear(1);
      chk("R4 cleared", flag_open, 0);
      chk("R8 fault low", fault_pin, 0);

      // R7 qualifiers
      ch_on = 2'b01; open_det = 2'b01; under_det = 2'b10; cyc(2 * F);
      chk("R7 open ignored on", flag_open, 0);
      chk("R7 under ignored off", flag_under, 0);
      under_det = 2'b01; open_det = 0; cyc(F + 1);
      chk("R7 under when on", flag_under, 2'b01);
      under_det = 0; vclear(1);

      // R6 overtemp one-cycle pulse
      otemp_det = 2'b10; cyc(1);
      otemp_det = 0;
      chk("R6 ot latched", flag_prot, 2'b10);
      vclear(1);
      chk("R6 ot cleared", flag_prot, 0);

      // R5 latching current-limit hold
      cl2_mode = 2'b01; in_lvl = 2'b11; ch_on = 2'b11; ovl_det = 2'b11;
      cyc(F + 1);
      chk("R5 ovl set", flag_prot, 2'b11);
      ovl_det = 0; vclear(1);
      chk("R5 held ch0, cleared ch1", flag_prot, 2'b01);
      in_lvl = 2'b00; ch_on = 2'b00; vclear(1);
      chk("R5 cleared input low", flag_prot, 0);
      cl2_mode = 0;

      // R9 persisting short re-latches
      short_det = 2'b10; cyc(F + 1);
      chk("R9 short set", flag_short, 2'b10);
      vclear(1);
      chk("R9 cleared", flag_short, 0);
      cyc(F);
      chk("R9 still low", flag_short, 0);
      cyc(1);
      chk("R9 relatched", flag_short, 2'b10);
      short_det = 0; vclear(1);

      // random phase
      void'($urandom(32'd4711));
      for (int n = 0; n < 1500; n++) begin
         for (int c = 0; c < NC; c++) begin
            if ($urandom_range(7) == 0) ovl_det[c]   = ~ovl_det[c];
            if ($urandom_range(31) == 0) otemp_det[c] = ~otemp_det[c];
            if ($urandom_range(7) == 0) open_det[c]  = ~open_det[c];
            if ($urandom_range(7) == 0) under_det[c] = ~under_det[c];
            if ($urandom_range(7) == 0) short_det[c] = ~short_det[c];
            if ($urandom_range(11) == 0) ch_on[c]    = ~ch_on[c];
            if ($urandom_range(9) == 0) in_lvl[c]    = ~in_lvl[c];
            if ($urandom_range(63) == 0) cl2_mode[c] = ~cl2_mode[c];
         end
         if ($urandom_range(5) == 0) cs_n = ~cs_n;
         frame_ok = $urandom_range(1);
         cyc(1);
      end
      done = 1;
   end

   initial begin
      for (int i = 0; i < 100000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule